// File: doc/BRIEF.md
# Self-Timed Program Cycle Controller

This block sits behind the serial command decoder of a small byte-wide nonvolatile store. It takes decoded commands (enable, disable, single-word write, single-word erase, fill-all and clear-all) and holds a program-enable latch that starts out cleared. A modifying command that arrives while the latch is set becomes pending. Nothing happens to the array until the chip-select input falls. That falling edge launches a self-timed cycle that runs from the system clock alone, so the serial clock plays no part in it.

During the cycle the controller drives a one-word-wide write port into the array. A single-word write first erases the word to all ones and then programs it half a cycle later. The fill-all and clear-all commands use a broadcast flag so that the array updates every word in the same clock. A status bit for the serial output mux reads low while a cycle is running and chip select is high. It reads high at all other times, which the host uses to poll for completion. A one-clock done pulse marks the end of every cycle.

Top module: `eeprog_ctrl`

## Requirements
- R1: After reset the enable latch is clear, busy and done are low, status_do is high and mem_we is low.
- R2: Command codes on cmd_op are 1 enable, 2 disable, 3 write, 4 erase, 5 fill-all and 6 clear-all. Codes 0 and 7 are ignored. While the latch is clear, codes 3 to 6 leave busy low and produce no mem_we when chip select later falls.
- R3: The enable latch stays set across any number of completed cycles. A disable command clears it and also drops any pending command, so a later chip-select fall starts nothing.
- R4: A pending command starts only on a falling edge of cs. Busy rises on the clock after the edge that samples cs low with cs high the clock before. With cs held high, a pending command waits indefinitely.
- R5: Busy stays high for exactly CYCLE_CLKS clocks and needs no input activity to finish.
- R6: status_do is low while busy is high and cs is high. It is high whenever busy is low or cs is low.
- R7: A write gives two mem_we pulses to the addressed word. The first, in the first busy clock, carries all ones. The second, in busy clock CYCLE_CLKS/2, carries cmd_data.
- R8: An erase gives exactly one mem_we pulse, in the first busy clock, writing all ones to the addressed word.
- R9: Fill-all and clear-all raise mem_all with each mem_we pulse. Clear-all writes all ones in the first busy clock. Fill-all writes all ones in the first busy clock and then the byte in busy clock CYCLE_CLKS/2.
- R10: Every command that arrives while busy is high is discarded, enable and disable included.
- R11: done is high for exactly one clock, the first clock after busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the timebase of the cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-clock strobe for a decoded command |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | ADDR_W | Word address of the command |
| cmd_data | input | DATA_W | Byte to program |
| cs | input | 1 | Chip-select level |
| busy | output | 1 | A self-timed cycle is running |
| done | output | 1 | One-clock pulse at the end of a cycle |
| status_do | output | 1 | Ready/busy bit for the serial output mux |
| mem_we | output | 1 | Array write strobe |
| mem_all | output | 1 | Apply the write to every word |
| mem_addr | output | ADDR_W | Array word address |
| mem_wdata | output | DATA_W | Array write data |

## Verification
The bound checker watches several rules on every clock. It checks that busy lasts exactly the configured length, that busy rises only after chip select was seen low, and that array writes occur only inside a cycle. It also checks that the first write of a cycle is always all ones, that the broadcast flag only comes with a write strobe, that status stays low while busy with chip select high, and that done is a single pulse. Other behaviours span several commands and can only be shown by the bench's scenarios. These include the gating by the enable latch, the sticky latch, cancellation by disable, commands dropped while busy, and the final array contents after a sweep of writes and erases over every address. The bench checks these against a memory model that it updates arithmetically.

// File: rtl/eeprog_pkg.sv
package eeprog_pkg;
  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_ENABLE  = 3'd1,
    OP_DISABLE = 3'd2,
    OP_WRITE   = 3'd3,
    OP_ERASE   = 3'd4,
    OP_FILL    = 3'd5,
    OP_CLEAR   = 3'd6,
    OP_RSVD    = 3'd7
  } op_e;
endpackage

// File: rtl/eeprog_cmd_gate.sv
module eeprog_cmd_gate
  import eeprog_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              cs,
  input  logic              busy,
  output logic              start,
  output op_e               pend_op,
  output logic [ADDR_W-1:0] pend_addr,
  output logic [DATA_W-1:0] pend_data
);
  logic en_q, en_d;
  logic pv_q, pv_d;
  logic cs_q;
  logic take, load;
  op_e  op_in;

  assign op_in = op_e'(cmd_op);
  assign start = pv_q & cs_q & ~cs & ~busy;
  assign take  = cmd_valid & ~busy & ~start;

  always_comb begin
    en_d = en_q;
    pv_d = pv_q;
    load = 1'b0;
    if (start) begin
      pv_d = 1'b0;
    end else if (take) begin
      case (op_in)
        OP_ENABLE:  en_d = 1'b1;
        OP_DISABLE: begin
          en_d = 1'b0;
          pv_d = 1'b0;
        end
        OP_WRITE, OP_ERASE, OP_FILL, OP_CLEAR: begin
          if (en_q) begin
            pv_d = 1'b1;
            load = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      pv_q <= 1'b0;
      cs_q <= 1'b0;
    end else begin
      en_q <= en_d;
      pv_q <= pv_d;
      cs_q <= cs;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_op   <= OP_NONE;
      pend_addr <= '0;
      pend_data <= '0;
    end else if (load) begin
      pend_op   <= op_in;
      pend_addr <= cmd_addr;
      pend_data <= cmd_data;
    end
  end
endmodule

// File: rtl/eeprog_cycle_timer.sv
module eeprog_cycle_timer #(
  parameter int CYCLE_CLKS = 16,
  localparam int CNT_W = $clog2(CYCLE_CLKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic [CNT_W-1:0] cnt,
  output logic             done
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLE_CLKS - 1);

  logic             busy_d, done_d;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    busy_d = busy;
    cnt_d  = cnt;
    done_d = 1'b0;
    if (busy) begin
      if (cnt == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt + 1'b1;
      end
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      busy <= busy_d;
      cnt  <= cnt_d;
      done <= done_d;
    end
  end
endmodule

// File: rtl/eeprog_array_port.sv
module eeprog_array_port
  import eeprog_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 8,
  parameter int CYCLE_CLKS = 16,
  localparam int CNT_W = $clog2(CYCLE_CLKS)
) (
  input  logic              busy,
  input  logic [CNT_W-1:0]  cnt,
  input  op_e               op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              mem_we,
  output logic              mem_all,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(CYCLE_CLKS / 2);

  logic erase_step, prog_step;

  assign erase_step = busy && (cnt == '0);
  assign prog_step  = busy && (cnt == HALF);
  assign mem_addr   = addr;
  assign mem_wdata  = prog_step ? data : '1;

  always_comb begin
    mem_we  = 1'b0;
    mem_all = 1'b0;
    case (op)
      OP_WRITE: mem_we = erase_step | prog_step;
      OP_ERASE: mem_we = erase_step;
      OP_FILL: begin
        mem_we  = erase_step | prog_step;
        mem_all = erase_step | prog_step;
      end
      OP_CLEAR: begin
        mem_we  = erase_step;
        mem_all = erase_step;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/eeprog_ctrl.sv
module eeprog_ctrl
  import eeprog_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 8,
  parameter int CYCLE_CLKS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              cs,
  output logic              busy,
  output logic              done,
  output logic              status_do,
  output logic              mem_we,
  output logic              mem_all,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int CNT_W = $clog2(CYCLE_CLKS);

  logic              start;
  op_e               pend_op;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;
  logic [CNT_W-1:0]  cnt;

  eeprog_cmd_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cs(cs), .busy(busy),
    .start(start), .pend_op(pend_op), .pend_addr(pend_addr),
    .pend_data(pend_data)
  );

  eeprog_cycle_timer #(.CYCLE_CLKS(CYCLE_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .cnt(cnt),
    .done(done)
  );

  eeprog_array_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
                      .CYCLE_CLKS(CYCLE_CLKS)) u_port (
    .busy(busy), .cnt(cnt), .op(pend_op), .addr(pend_addr),
    .data(pend_data), .mem_we(mem_we), .mem_all(mem_all),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  assign status_do = ~(busy & cs);
endmodule

// File: rtl/eeprog_ctrl_chk.sv
module eeprog_ctrl_chk #(
  parameter int DATA_W     = 8,
  parameter int CYCLE_CLKS = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs,
  input logic              busy,
  input logic              done,
  input logic              status_do,
  input logic              mem_we,
  input logic              mem_all,
  input logic [DATA_W-1:0] mem_wdata
);
  localparam int LEN_W = $clog2(CYCLE_CLKS) + 2;

  logic [LEN_W-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == LEN_W'(CYCLE_CLKS)));

  // R4
  start_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!cs));

  // R7
  we_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R7
  erase_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $rose(busy)) |-> (mem_wdata == '1));

  // R9
  all_needs_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_all |-> mem_we);

  // R6
  status_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cs) |-> !status_do);

  // R11
  done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(busy));

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind eeprog_ctrl eeprog_ctrl_chk #(.DATA_W(DATA_W), .CYCLE_CLKS(CYCLE_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .busy(busy), .done(done),
  .status_do(status_do), .mem_we(mem_we), .mem_all(mem_all),
  .mem_wdata(mem_wdata)
);

// File: tb/sim_eeprog_ctrl.sv
module sim_eeprog_ctrl;
  import eeprog_pkg::*;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NC = 8;
  localparam int WORDS = 1 << AW;

  logic          clk, rst_n, cmd_valid, cs;
  logic [2:0]    cmd_op;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;
  logic          busy, done, status_do, mem_we, mem_all;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  int checks = 0;
  int errors = 0;
  int we_cnt = 0;
  logic [DW-1:0] arr [WORDS];
  logic [DW-1:0] exp_mem [WORDS];

  eeprog_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CYCLE_CLKS(NC)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cs(cs), .busy(busy),
    .done(done), .status_do(status_do), .mem_we(mem_we), .mem_all(mem_all),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (rst_n && mem_we) begin
      we_cnt <= we_cnt + 1;
      if (mem_all) begin
        for (int i = 0; i < WORDS; i++) arr[i] <= mem_wdata;
      end else begin
        arr[mem_addr] <= mem_wdata;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic send(input logic [2:0] op, input int a, input int d);
    @(negedge clk);
    cs = 1'b1;
    cmd_valid = 1'b1;
    cmd_op = op;
    cmd_addr = AW'(a);
    cmd_data = DW'(d);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic compare_mem(input string req);
    int bad = 0;
    int first = -1;
    for (int i = 0; i < WORDS; i++) begin
      if (arr[i] !== exp_mem[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    end
    chk(bad == 0, req, (first < 0) ? 0 : int'(arr[first]),
        (first < 0) ? 0 : int'(exp_mem[first]));
  endtask

  // send, lower cs, observe the whole window
  task automatic run_op(input logic [2:0] op, input int a, input int d,
                        input bit expect_run, input string req);
    int we0, bcnt, dcnt, nwr;
    send(op, a, d);
    we0 = we_cnt;
    @(negedge clk);
    cs = 1'b0;
    bcnt = 0;
    dcnt = 0;
    for (int k = 0; k < NC + 3; k++) begin
      @(negedge clk);
      if (busy) bcnt++;
      if (done) dcnt++;
    end
    nwr = 0;
    if (expect_run) begin
      case (op)
        3'd3: begin nwr = 2; exp_mem[a] = DW'(d); end
        3'd4: begin nwr = 1; exp_mem[a] = '1; end
        3'd5: begin nwr = 2; for (int i = 0; i < WORDS; i++) exp_mem[i] = DW'(d); end
        3'd6: begin nwr = 1; for (int i = 0; i < WORDS; i++) exp_mem[i] = '1; end
        default: nwr = 0;
      endcase
    end
    chk(bcnt == (expect_run ? NC : 0), {req, " R5 busy length"}, bcnt, expect_run ? NC : 0);
    chk(dcnt == (expect_run ? 1 : 0), {req, " R11 done count"}, dcnt, expect_run ? 1 : 0);
    chk((we_cnt - we0) == nwr, {req, " write strobes"}, we_cnt - we0, nwr);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    cmd_op = 3'd0;
    cmd_addr = '0;
    cmd_data = '0;
    cs = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy, "R1 busy", int'(busy), 0);
    chk(status_do, "R1 status_do", int'(status_do), 1);
    chk(!done && !mem_we, "R1 done/mem_we", int'(done) + int'(mem_we), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 modifying commands while latch clear, and unused codes
    run_op(3'd3, 2, 8'h11, 1'b0, "R2 write disabled");
    run_op(3'd4, 3, 0, 1'b0, "R2 erase disabled");
    run_op(3'd5, 0, 8'h22, 1'b0, "R2 fill disabled");
    run_op(3'd6, 0, 0, 1'b0, "R2 clear disabled");
    run_op(3'd0, 0, 0, 1'b0, "R2 code 0");
    run_op(3'd7, 0, 0, 1'b0, "R2 code 7");
    run_op(3'd1, 0, 0, 1'b0, "R2 enable no cycle");

    // R9 clear-all, fill-all
    run_op(3'd6, 0, 0, 1'b1, "R9 clear-all");
    compare_mem("R9 clear-all contents");
    run_op(3'd5, 0, 8'h3C, 1'b1, "R9 fill-all");
    compare_mem("R9 fill-all contents");

    // R7 write sweep over every address; R3 latch stays set throughout
    for (int a = 0; a < WORDS; a++) run_op(3'd3, a, (a * 29 + 7) & 8'hFF, 1'b1, "R7 R3 write");
    compare_mem("R7 write sweep contents");

    // R8 erase on even addresses
    for (int a = 0; a < WORDS; a += 2) run_op(3'd4, a, 0, 1'b1, "R8 erase");
    compare_mem("R8 erase sweep contents");

    // R4 pending command waits while cs stays high
    begin
      int we0;
      send(3'd3, 5, 8'hA5);
      we0 = we_cnt;
      repeat (NC + 4) @(negedge clk);
      chk(!busy && (we_cnt == we0), "R4 no start while cs high", int'(busy), 0);
      cs = 1'b0;
      @(negedge clk);
      chk(busy, "R4 busy after cs fall", int'(busy), 1);
      // R6 status with cs low then high while busy
      chk(status_do, "R6 status high with cs low", int'(status_do), 1);
      cs = 1'b1;
      @(negedge clk);
      chk(!status_do, "R6 status low while busy", int'(status_do), 0);
      // R10 commands during busy are discarded
      cmd_valid = 1'b1;
      cmd_op = 3'd2;
      @(negedge clk);
      cmd_op = 3'd4;
      cmd_addr = AW'(6);
      @(negedge clk);
      cmd_valid = 1'b0;
      cs = 1'b0;
      @(negedge clk);
      cs = 1'b1;
      repeat (NC) @(negedge clk);
      chk(!busy && status_do, "R6 status high after cycle", int'(status_do), 1);
      chk((we_cnt - we0) == 2, "R10 dropped erase made no writes", we_cnt - we0, 2);
      exp_mem[5] = 8'hA5;
      compare_mem("R10 contents after busy commands");
      cs = 1'b0;
      @(negedge clk);
    end
    // R10 dropped disable left the latch set
    run_op(3'd3, 9, 8'h5E, 1'b1, "R10 latch still set");

    // R3 disable cancels a pending command and blocks later ones
    send(3'd3, 1, 8'h77);
    run_op(3'd2, 0, 0, 1'b0, "R3 disable cancels pending");
    run_op(3'd3, 1, 8'h77, 1'b0, "R3 write after disable");
    run_op(3'd1, 0, 0, 1'b0, "R3 re-enable");
    run_op(3'd3, 1, 8'h77, 1'b1, "R3 write after re-enable");
    compare_mem("R3 final contents");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule